// File: doc/BRIEF.md
# LDPC Variable Node Update Unit

This block performs the variable-node half of an iteration in an 8-bit message-passing LDPC decoder. For each node, it receives a serial stream of beats. The first beat carries the channel LLR. Each later beat carries one check-to-variable message. All values are signed integers in units of 1/8, so the representable range is ±15.875. The block sums every input into a total U. It then replays the stored check messages in arrival order and emits one extrinsic message per edge on consecutive cycles. It also reports the sign of U as the hard decision for the node.

Two static configuration inputs change the arithmetic. The first saturates the total to the message range before each edge's own message is subtracted. This trades some intuitive accuracy for a better chance of escaping trapping sets. The second limits the channel LLR of a node that has exactly one check edge to a smaller magnitude, so that a single strong check message can still overturn a confident but wrong channel value.

Input beats are accepted while the unit is idle or accumulating. They are dropped while the output pass runs, and `busy_o` is high for that whole pass.

Top module: `vn_update_unit`

## Requirements
- R1: After reset, `out_valid_o`, `hard_valid_o` and `busy_o` are low.
- R2: With total clipping off, the message for edge j is sat(U − u_j). U is the effective channel LLR plus every stored check message. The messages leave one per cycle in arrival order, the first one in the cycle after the clock edge that takes the beat flagged last.
- R3: Every message is saturated to [−127, +127], and an input of −128 is treated as −127. No output ever carries −128 (0x80).
- R4: With `cfg_total_clip_i` = 1, the message for edge j is sat(sat(U) − u_j).
- R5: With `cfg_deg1_clip_i` = 1 and exactly one check edge, the channel LLR is limited to ±116 before it enters U. With more than one edge, the channel LLR is used unchanged.
- R6: `hard_valid_o` pulses for one cycle, in the same cycle as the first output message. `hard_bit_o` is then 1 when U < 0 and 0 when U ≥ 0.
- R7: `out_last_o` is high only with the final message of a node. `busy_o` is high throughout the output pass. Beats presented during the output pass are ignored.
- R8: A beat with both start and last set describes a node of degree 0. It produces the hard-decision pulse in the next cycle and no output messages.
- R9: Check beats beyond MAX_DEG (default 8) are dropped. They are not summed and not emitted.
- R10: A start beat that arrives while a node is being accumulated discards the partial node and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_total_clip_i | input | 1 | Saturate the total before the extrinsic subtraction |
| cfg_deg1_clip_i | input | 1 | Limit the channel LLR of degree-1 nodes to ±116 |
| in_valid_i | input | 1 | Input beat present |
| in_start_i | input | 1 | The beat is the channel LLR of a new node |
| in_last_i | input | 1 | Final beat of the node |
| in_msg_i | input | MSG_W | Signed LLR or check message |
| out_valid_o | output | 1 | Extrinsic message valid |
| out_last_o | output | 1 | Final extrinsic message of the node |
| out_msg_o | output | MSG_W | Signed extrinsic message |
| hard_valid_o | output | 1 | Hard decision valid, one-cycle pulse |
| hard_bit_o | output | 1 | Hard decision, 1 = negative total |
| busy_o | output | 1 | Output pass in progress |

## Verification
A corrupted total or a wrong stored edge shows up within the same output pass. Each extrinsic message exposes U − u_j directly. A total that is offset by a constant therefore shifts every message, while a misordered or overwritten entry corrupts exactly one slot. Clipping faults only appear near the rails, so the vectors deliberately push U beyond ±127 and place the degree-1 channel LLR above 116. A sequencing fault shows up as a missing or extra `out_valid_o` cycle or a misplaced `out_last_o`, visible within one node's length.

// File: rtl/vn_pkg.sv
package vn_pkg;
  typedef enum logic [1:0] {
    VN_IDLE = 2'd0,
    VN_ACC  = 2'd1,
    VN_OUT  = 2'd2
  } vn_state_e;
endpackage

// File: rtl/vn_edge_store.sv
module vn_edge_store #(
  parameter int MSG_W   = 8,
  parameter int MAX_DEG = 8,
  parameter int CNT_W   = $clog2(MAX_DEG + 1),
  parameter int SUM_W   = MSG_W + CNT_W,
  parameter int IDX_W   = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    wr_i,
  input  logic signed [MSG_W-1:0] msg_i,
  input  logic [IDX_W-1:0]        rd_idx_i,
  output logic signed [MSG_W-1:0] rd_msg_o,
  output logic signed [SUM_W-1:0] sum_o,
  output logic [CNT_W-1:0]        cnt_o
);
  logic signed [MSG_W-1:0] mem_q [MAX_DEG];
  logic [CNT_W-1:0]        cnt_q;
  logic signed [SUM_W-1:0] sum_q;
  logic                    wr_ok;

  // beats past MAX_DEG are dropped
  assign wr_ok = wr_i && (cnt_q < CNT_W'(MAX_DEG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (wr_ok) begin
      cnt_q <= cnt_q + CNT_W'(1);
      sum_q <= sum_q + SUM_W'(msg_i);
    end
  end

  for (genvar g = 0; g < MAX_DEG; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[g] <= '0;
      else if (wr_ok && cnt_q == CNT_W'(g))     mem_q[g] <= msg_i;
    end
  end

  assign rd_msg_o = mem_q[rd_idx_i];
  assign sum_o    = sum_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/vn_total.sv
module vn_total #(
  parameter int MSG_W    = 8,
  parameter int CNT_W    = 4,
  parameter int SUM_W    = 12,
  parameter int DEG1_MAG = 116
) (
  input  logic signed [MSG_W-1:0] chan_i,
  input  logic signed [SUM_W-1:0] sum_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    cfg_total_clip_i,
  input  logic                    cfg_deg1_clip_i,
  output logic signed [SUM_W-1:0] ut_o,
  output logic                    hard_o
);
  localparam int MSG_MAX = 2 ** (MSG_W - 1) - 1;
  localparam logic signed [MSG_W-1:0] D1_HI = MSG_W'(DEG1_MAG);
  localparam logic signed [MSG_W-1:0] D1_LO = -D1_HI;
  localparam logic signed [SUM_W-1:0] T_HI  = SUM_W'(MSG_MAX);
  localparam logic signed [SUM_W-1:0] T_LO  = -T_HI;

  logic signed [MSG_W-1:0] ch_eff;
  logic signed [SUM_W-1:0] u_full;

  always_comb begin
    ch_eff = chan_i;
    if (cfg_deg1_clip_i && cnt_i == CNT_W'(1)) begin
      if (chan_i > D1_HI)      ch_eff = D1_HI;
      else if (chan_i < D1_LO) ch_eff = D1_LO;
    end
  end

  assign u_full = sum_i + SUM_W'(ch_eff);
  assign hard_o = u_full[SUM_W-1];

  always_comb begin
    ut_o = u_full;
    if (cfg_total_clip_i) begin
      if (u_full > T_HI)      ut_o = T_HI;
      else if (u_full < T_LO) ut_o = T_LO;
    end
  end
endmodule

// File: rtl/vn_extrinsic.sv
module vn_extrinsic #(
  parameter int MSG_W = 8,
  parameter int SUM_W = 12
) (
  input  logic signed [SUM_W-1:0] ut_i,
  input  logic signed [MSG_W-1:0] u_i,
  output logic signed [MSG_W-1:0] msg_o
);
  localparam int DIFF_W  = SUM_W + 1;
  localparam int MSG_MAX = 2 ** (MSG_W - 1) - 1;
  localparam logic signed [DIFF_W-1:0] D_HI = DIFF_W'(MSG_MAX);
  localparam logic signed [DIFF_W-1:0] D_LO = -D_HI;

  logic signed [DIFF_W-1:0] diff;

  assign diff = DIFF_W'(ut_i) - DIFF_W'(u_i);

  always_comb begin
    if (diff > D_HI)      msg_o = D_HI[MSG_W-1:0];
    else if (diff < D_LO) msg_o = D_LO[MSG_W-1:0];
    else                  msg_o = diff[MSG_W-1:0];
  end
endmodule

// File: rtl/vn_update_unit.sv
module vn_update_unit
  import vn_pkg::*;
#(
  parameter int MSG_W    = 8,
  parameter int MAX_DEG  = 8,
  parameter int DEG1_MAG = 116
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_total_clip_i,
  input  logic                    cfg_deg1_clip_i,
  input  logic                    in_valid_i,
  input  logic                    in_start_i,
  input  logic                    in_last_i,
  input  logic signed [MSG_W-1:0] in_msg_i,
  output logic                    out_valid_o,
  output logic                    out_last_o,
  output logic signed [MSG_W-1:0] out_msg_o,
  output logic                    hard_valid_o,
  output logic                    hard_bit_o,
  output logic                    busy_o
);
  localparam int CNT_W = $clog2(MAX_DEG + 1);
  localparam int SUM_W = MSG_W + CNT_W;
  localparam int IDX_W = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1;
  localparam logic signed [MSG_W-1:0] NEG_RAIL = {1'b1, {(MSG_W-1){1'b0}}};
  localparam logic signed [MSG_W-1:0] NEG_SAT  = NEG_RAIL + MSG_W'(1);

  vn_state_e               state_q;
  logic signed [MSG_W-1:0] chan_q;
  logic                    hard_q;
  logic [IDX_W-1:0]        rd_q;
  logic signed [MSG_W-1:0] in_sat;
  logic                    accept, start_acc, edge_wr, rd_last;
  logic signed [MSG_W-1:0] rd_msg;
  logic signed [SUM_W-1:0] sum;
  logic [CNT_W-1:0]        cnt;
  logic signed [SUM_W-1:0] ut;
  logic                    hard;

  assign in_sat    = (in_msg_i == NEG_RAIL) ? NEG_SAT : in_msg_i;
  assign accept    = in_valid_i && (state_q != VN_OUT);
  assign start_acc = accept && in_start_i;
  assign edge_wr   = accept && !in_start_i && (state_q == VN_ACC);
  assign rd_last   = (CNT_W'(rd_q) + CNT_W'(1)) == cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= VN_IDLE;
      chan_q  <= '0;
      hard_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      hard_q <= 1'b0;
      if (start_acc) begin
        chan_q <= in_sat;
        rd_q   <= '0;
        if (in_last_i) begin
          state_q <= VN_IDLE;
          hard_q  <= 1'b1;
        end else begin
          state_q <= VN_ACC;
        end
      end else if (edge_wr && in_last_i) begin
        state_q <= VN_OUT;
        hard_q  <= 1'b1;
        rd_q    <= '0;
      end else if (state_q == VN_OUT) begin
        if (rd_last) state_q <= VN_IDLE;
        else         rd_q    <= rd_q + IDX_W'(1);
      end
    end
  end

  vn_edge_store #(
    .MSG_W(MSG_W), .MAX_DEG(MAX_DEG), .CNT_W(CNT_W), .SUM_W(SUM_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_acc),
    .wr_i     (edge_wr),
    .msg_i    (in_sat),
    .rd_idx_i (rd_q),
    .rd_msg_o (rd_msg),
    .sum_o    (sum),
    .cnt_o    (cnt)
  );

  vn_total #(
    .MSG_W(MSG_W), .CNT_W(CNT_W), .SUM_W(SUM_W), .DEG1_MAG(DEG1_MAG)
  ) u_total (
    .chan_i           (chan_q),
    .sum_i            (sum),
    .cnt_i            (cnt),
    .cfg_total_clip_i (cfg_total_clip_i),
    .cfg_deg1_clip_i  (cfg_deg1_clip_i),
    .ut_o             (ut),
    .hard_o           (hard)
  );

  vn_extrinsic #(.MSG_W(MSG_W), .SUM_W(SUM_W)) u_ext (
    .ut_i  (ut),
    .u_i   (rd_msg),
    .msg_o (out_msg_o)
  );

  assign out_valid_o  = (state_q == VN_OUT);
  assign out_last_o   = (state_q == VN_OUT) && rd_last;
  assign busy_o       = (state_q == VN_OUT);
  assign hard_valid_o = hard_q;
  assign hard_bit_o   = hard;
endmodule

// File: rtl/vn_update_unit_chk.sv
module vn_update_unit_chk #(
  parameter int MSG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             out_valid_o,
  input logic             out_last_o,
  input logic [MSG_W-1:0] out_msg_o,
  input logic             hard_valid_o,
  input logic             busy_o
);
  localparam logic [MSG_W-1:0] RAIL = {1'b1, {(MSG_W-1){1'b0}}};

  assert_no_neg_rail_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_msg_o != RAIL);

  assert_hard_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_valid_o |=> !hard_valid_o);

  assert_last_in_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  assert_busy_cover_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> busy_o);

  assert_burst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |=> out_valid_o);

  assert_pass_ends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |=> !out_valid_o);

  assert_pass_opens_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> hard_valid_o);
endmodule

bind vn_update_unit vn_update_unit_chk #(.MSG_W(MSG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .out_valid_o  (out_valid_o),
  .out_last_o   (out_last_o),
  .out_msg_o    (out_msg_o),
  .hard_valid_o (hard_valid_o),
  .busy_o       (busy_o)
);

// File: tb/sim_vn_update_unit.sv
`timescale 1ns/1ps
module sim_vn_update_unit;
  localparam int MAX_DEG = 8;
  localparam int NV      = 10;

  // stimulus table: channel, degree, edges, total clip, degree-1 clip
  localparam int V_CH  [NV] = '{10, 127, 127, -128, -128, 127, 127, 127, 5, -40};
  localparam int V_DEG [NV] = '{3, 3, 3, 2, 2, 1, 1, 2, 2, 4};
  localparam int V_U   [NV][4] = '{
    '{20, -5, 7, 0}, '{127, 127, 127, 0}, '{127, 127, 127, 0},
    '{-128, -128, 0, 0}, '{-128, -128, 0, 0}, '{-120, 0, 0, 0},
    '{-120, 0, 0, 0}, '{-120, 0, 0, 0}, '{-3, -2, 0, 0},
    '{30, -60, 100, -127}};
  localparam bit V_TC [NV] = '{0, 0, 1, 0, 1, 0, 0, 0, 0, 1};
  localparam bit V_DC [NV] = '{0, 0, 0, 0, 0, 1, 0, 1, 0, 1};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_t = 1'b0, cfg_d = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
  logic signed [7:0] in_msg = '0;
  logic out_valid, out_last, hard_valid, hard_bit, busy;
  logic signed [7:0] out_msg;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  vn_update_unit #(.MSG_W(8), .MAX_DEG(MAX_DEG), .DEG1_MAG(116)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_total_clip_i(cfg_t), .cfg_deg1_clip_i(cfg_d),
    .in_valid_i(in_valid), .in_start_i(in_start), .in_last_i(in_last), .in_msg_i(in_msg),
    .out_valid_o(out_valid), .out_last_o(out_last), .out_msg_o(out_msg),
    .hard_valid_o(hard_valid), .hard_bit_o(hard_bit), .busy_o(busy));

  function automatic int sat(int x, int m);
    if (x > m) return m;
    if (x < -m) return -m;
    return x;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic beat(bit s, bit l, int m);
    @(negedge clk);
    in_valid = 1'b1; in_start = s; in_last = l; in_msg = 8'(m);
  endtask

  // waits for the output pass and compares with the reference arithmetic
  task automatic collect(int ch, int deg, int u[16], bit tc, bit dc, bit noise, string req);
    int n, tot, ut, ce, exp;
    n = (deg > MAX_DEG) ? MAX_DEG : deg;
    ce = sat(ch, 127);
    if (dc && n == 1) ce = sat(ce, 116);
    tot = ce;
    for (int k = 0; k < n; k++) tot += sat(u[k], 127);
    ut = tc ? sat(tot, 127) : tot;
    @(negedge clk);
    if (noise) begin
      in_valid = 1'b1; in_start = 1'b1; in_last = 1'b1; in_msg = -8'sd100;
    end else in_valid = 1'b0;
    check(hard_valid == 1'b1, {req, " R6 hard_valid"}, hard_valid, 1);
    check(hard_bit == (tot < 0), {req, " R6 hard_bit"}, hard_bit, (tot < 0));
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      exp = sat(ut - sat(u[k], 127), 127);
      check(out_valid && busy && int'(out_msg) == exp, {req, " R2 msg"}, out_msg, exp);
      check(out_last == (k == n - 1), {req, " R7 last"}, out_last, (k == n - 1));
    end
    in_valid = 1'b0;
    @(negedge clk);
    check(!out_valid && !busy, {req, " R7 pass end"}, out_valid, 0);
    if (noise) check(!hard_valid, "R7 ignored beat", hard_valid, 0);
  endtask

  task automatic run_node(int ch, int deg, int u[16], bit tc, bit dc, bit noise, string req);
    cfg_t = tc; cfg_d = dc;
    beat(1'b1, 1'b0, ch);
    for (int k = 0; k < deg; k++) beat(1'b0, k == deg - 1, u[k]);
    collect(ch, deg, u, tc, dc, noise, req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 100000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int u[16];
    repeat (3) @(negedge clk);
    check(!out_valid && !hard_valid && !busy, "R1 reset", out_valid, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!out_valid && !hard_valid && !busy, "R1 after release", busy, 0);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < 16; k++) u[k] = (k < 4) ? V_U[v][k] : 0;
      run_node(V_CH[v], V_DEG[v], u, V_TC[v], V_DC[v], 1'b0, $sformatf("R2 R3 R4 R5 vec%0d", v));
    end

    // R8: degree-0 node
    cfg_t = 0; cfg_d = 0;
    beat(1'b1, 1'b1, -3);
    @(negedge clk);
    in_valid = 1'b0;
    check(hard_valid && hard_bit, "R8 hard", hard_bit, 1);
    check(!out_valid, "R8 no output", out_valid, 0);
    @(negedge clk);
    check(!out_valid && !hard_valid, "R8 quiet", out_valid, 0);

    // R7: beats during the output pass are ignored
    for (int k = 0; k < 16; k++) u[k] = 0;
    u[0] = 40; u[1] = -9; u[2] = 3;
    run_node(-20, 3, u, 1'b0, 1'b0, 1'b1, "R7 busy ignore");

    // R10: restart while accumulating
    cfg_t = 0; cfg_d = 0;
    beat(1'b1, 1'b0, 50);
    beat(1'b0, 1'b0, 10);
    beat(1'b1, 1'b0, 1);
    beat(1'b0, 1'b0, 2);
    beat(1'b0, 1'b1, 3);
    for (int k = 0; k < 16; k++) u[k] = 0;
    u[0] = 2; u[1] = 3;
    collect(1, 2, u, 1'b0, 1'b0, 1'b0, "R10 restart");

    // R9: beats beyond MAX_DEG dropped
    for (int k = 0; k < 16; k++) u[k] = (k < MAX_DEG) ? 1 : 100;
    run_node(0, MAX_DEG + 2, u, 1'b0, 1'b0, 1'b0, "R9 overflow");

    // R5: degree-1 clip at the negative rail
    for (int k = 0; k < 16; k++) u[k] = 0;
    u[0] = 120;
    run_node(-127, 1, u, 1'b0, 1'b1, 1'b0, "R5 neg deg1");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule